// File: doc/BRIEF.md
# Ordered Two-Channel Breakpoint Trigger

This block raises a breakpoint request when two comparator channels report matches in a set order. The match strobes for channel A and channel B arrive as inputs, one strobe pair per monitored bus. A source selector picks which bus feeds the trigger. In ordered mode, a channel A strobe arms the unit. A later channel B strobe on its own then produces a one-cycle break request. An optional pass counter can require several B strobes before the break fires. In direct mode, any selected strobe produces a break.

Software controls the block through a small write port. That port sets the mode bits and the bus selector, loads the pass counter, and clears the two sticky match flags. Clearing the flags and leaving ordered mode abandons a half-finished sequence. Each output is registered, so a strobe in one cycle shows up on the outputs in the next cycle.

Register select (`wr_addr`):
- 0: control. Bit 0 is ordered mode. Bit 1 is counter gating. Bits starting at bit 2 are the bus selector.
- 1: flags. Writing 0 to bit 0 clears flag A. Writing 0 to bit 1 clears flag B. Writing 1 to a bit leaves that flag unchanged.
- 2: pass counter. The low `CNT_W` bits are loaded, and a value of 0 is loaded as 1.

Top module: `seqbrk_top`

## Requirements
- R1: With ordered mode (control bit 0) set and counter gating (control bit 1) clear, a lone B strobe after an A strobe makes `brk_o` high for exactly the one cycle after the B strobe.
- R2: With ordered mode set and no earlier A strobe (or none since the unit last disarmed), a B strobe raises no break.
- R3: In ordered mode, a cycle with A and B strobes together raises no break. The A strobe in that cycle still arms the unit.
- R4: Leaving ordered mode (control bit 0 = 0) disarms the unit. A later B strobe after re-entering ordered mode raises no break until a new A strobe arrives.
- R5: Only the strobes of the bus named by the selector field (control bits from bit 2 up) affect the flags and the break. Strobes on other buses are ignored.
- R6: With counter gating set, each lone B strobe while armed and with the counter above 1 decrements the counter by one. The break fires on the B strobe that finds the counter at 1, so a loaded value N fires on the Nth B strobe.
- R7: The pass counter never holds 0. A written 0 loads as 1, and the counter does not decrement below 1.
- R8: After a break fires in ordered mode the unit is disarmed, and further B strobes raise no break until a new A strobe.
- R9: Flags A and B (`flag_a_o`, `flag_b_o`) are set by a selected strobe of their channel in either mode. They stay set until a flag-register write with 0 in their bit (bit 0 for A, bit 1 for B).
- R10: With ordered mode clear, any selected A or B strobe makes `brk_o` high in the following cycle.
- R11: A synchronous active-low reset clears the mode bits, the selector, the flags, the armed state and `brk_o`, and loads the counter with 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 flags, 2 pass counter |
| wr_data | input | DATA_W | Write data |
| a_hit | input | NBUS | Channel A match strobe, one bit per bus |
| b_hit | input | NBUS | Channel B match strobe, one bit per bus |
| brk_o | output | 1 | Break request pulse |
| flag_a_o | output | 1 | Sticky channel A match flag |
| flag_b_o | output | 1 | Sticky channel B match flag |

## Verification
The assertions assume that the bus selector names an existing bus. They also assume that register writes and match strobes are independent single-cycle events. A write in the same cycle as a strobe is not given a defined order by the checks that follow the counter and flags. The stimulus keeps the selector within the bus count and never drives a write and a strobe in the same cycle. It sweeps every bus, both gating settings and counter loads from 1 to 4. Each sweep point follows the same pattern: arm with an A strobe, then send B strobes and compare the break against the position where it should fire.

// File: rtl/seqbrk_pkg.sv
package seqbrk_pkg;
   typedef enum logic [1:0] {
      REG_CTRL = 2'd0,
      REG_FLAG = 2'd1,
      REG_CNT  = 2'd2
   } reg_sel_e;

   localparam int CTRL_ORD_BIT  = 0;
   localparam int CTRL_GATE_BIT = 1;
   localparam int CTRL_SRC_LSB  = 2;
   localparam int FLAG_A_BIT    = 0;
   localparam int FLAG_B_BIT    = 1;

   typedef enum logic {
      ST_IDLE  = 1'b0,
      ST_ARMED = 1'b1
   } arm_state_e;
endpackage

// File: rtl/seqbrk_regs.sv
module seqbrk_regs #(
   parameter int DATA_W = 16,
   parameter int SEL_W  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              set_a,
   input  logic              set_b,
   output logic              ord_en,
   output logic              gate_en,
   output logic [SEL_W-1:0]  src_sel,
   output logic              flag_a,
   output logic              flag_b,
   output logic              clr_a,
   output logic              cnt_ld
);
   import seqbrk_pkg::*;

   logic wr_ctrl;
   logic wr_flag;
   logic clr_b;

   always_comb begin
      wr_ctrl = wr_en && (wr_addr == REG_CTRL);
      wr_flag = wr_en && (wr_addr == REG_FLAG);
      cnt_ld  = wr_en && (wr_addr == REG_CNT);
      clr_a   = wr_flag && !wr_data[FLAG_A_BIT];
      clr_b   = wr_flag && !wr_data[FLAG_B_BIT];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ord_en  <= 1'b0;
         gate_en <= 1'b0;
         src_sel <= '0;
      end else if (wr_ctrl) begin
         ord_en  <= wr_data[CTRL_ORD_BIT];
         gate_en <= wr_data[CTRL_GATE_BIT];
         src_sel <= wr_data[CTRL_SRC_LSB +: SEL_W];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_a <= 1'b0;
         flag_b <= 1'b0;
      end else begin
         flag_a <= set_a | (flag_a & ~clr_a);
         flag_b <= set_b | (flag_b & ~clr_b);
      end
   end
endmodule

// File: rtl/seqbrk_srcsel.sv
module seqbrk_srcsel #(
   parameter int NBUS  = 2,
   parameter int SEL_W = 1
) (
   input  logic [NBUS-1:0]  a_hit,
   input  logic [NBUS-1:0]  b_hit,
   input  logic [SEL_W-1:0] src_sel,
   output logic             hit_a,
   output logic             hit_b
);
   generate
      if (NBUS == 1) begin : g_single
         logic unused_sel;
         assign unused_sel = ^src_sel;
         assign hit_a = a_hit[0];
         assign hit_b = b_hit[0];
      end else begin : g_multi
         logic [NBUS-1:0] onehot;
         for (genvar i = 0; i < NBUS; i++) begin : g_dec
            assign onehot[i] = (src_sel == SEL_W'(i));
         end
         assign hit_a = |(a_hit & onehot);
         assign hit_b = |(b_hit & onehot);
      end
   endgenerate
endmodule

// File: rtl/seqbrk_seq.sv
module seqbrk_seq #(
   parameter int CNT_W  = 8,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ord_en,
   input  logic              gate_en,
   input  logic              hit_a,
   input  logic              hit_b,
   input  logic              cancel,
   input  logic              cnt_ld,
   input  logic [DATA_W-1:0] wr_data,
   output logic              brk,
   output logic              armed,
   output logic [CNT_W-1:0]  cnt_q
);
   import seqbrk_pkg::*;

   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   arm_state_e       st_q, st_d;
   logic             b_alone, qual, at_one, fire_ord, fire_dir, fire;
   logic [CNT_W-1:0] ld_val;

   always_comb begin
      b_alone  = hit_b & ~hit_a;
      qual     = (st_q == ST_ARMED) & b_alone;
      at_one   = (cnt_q == CNT_ONE);
      fire_ord = qual & (~gate_en | at_one);
      fire_dir = hit_a | hit_b;
      fire     = ord_en ? fire_ord : fire_dir;
      ld_val   = (wr_data[CNT_W-1:0] == '0) ? CNT_ONE : wr_data[CNT_W-1:0];
   end

   always_comb begin
      st_d = st_q;
      if (!ord_en || cancel)  st_d = ST_IDLE;
      else if (fire_ord)      st_d = ST_IDLE;
      else if (hit_a)         st_d = ST_ARMED;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         brk   <= 1'b0;
         cnt_q <= CNT_ONE;
      end else begin
         st_q <= st_d;
         brk  <= fire;
         if (cnt_ld)
            cnt_q <= ld_val;
         else if (ord_en && gate_en && qual && !at_one)
            cnt_q <= cnt_q - CNT_ONE;
      end
   end

   assign armed = (st_q == ST_ARMED);
endmodule

// File: rtl/seqbrk_top.sv
module seqbrk_top #(
   parameter int DATA_W = 16,
   parameter int NBUS   = 2,
   parameter int CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [NBUS-1:0]   a_hit,
   input  logic [NBUS-1:0]   b_hit,
   output logic              brk_o,
   output logic              flag_a_o,
   output logic              flag_b_o
);
   localparam int SEL_W = (NBUS > 1) ? $clog2(NBUS) : 1;

   generate
      if (NBUS < 1) begin : g_bad_nbus
         $error("seqbrk_top: NBUS must be at least 1");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("seqbrk_top: CNT_W must be at least 2");
      end
      if (DATA_W < CNT_W || DATA_W < 2 + SEL_W) begin : g_bad_data
         $error("seqbrk_top: DATA_W too narrow for fields");
      end
   endgenerate

   logic             ord_en, gate_en, flag_a, flag_b, clr_a, cnt_ld;
   logic [SEL_W-1:0] src_sel;
   logic             hit_a, hit_b, brk, armed;
   logic [CNT_W-1:0] cnt_q;

   seqbrk_srcsel #(.NBUS(NBUS), .SEL_W(SEL_W)) u_src (
      .a_hit(a_hit), .b_hit(b_hit), .src_sel(src_sel),
      .hit_a(hit_a), .hit_b(hit_b)
   );

   seqbrk_regs #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .set_a(hit_a), .set_b(hit_b),
      .ord_en(ord_en), .gate_en(gate_en), .src_sel(src_sel),
      .flag_a(flag_a), .flag_b(flag_b), .clr_a(clr_a), .cnt_ld(cnt_ld)
   );

   seqbrk_seq #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .ord_en(ord_en), .gate_en(gate_en),
      .hit_a(hit_a), .hit_b(hit_b), .cancel(clr_a), .cnt_ld(cnt_ld),
      .wr_data(wr_data), .brk(brk), .armed(armed), .cnt_q(cnt_q)
   );

   assign brk_o    = brk;
   assign flag_a_o = flag_a;
   assign flag_b_o = flag_b;
endmodule

// File: rtl/seqbrk_chk.sv
module seqbrk_chk #(
   parameter int DATA_W = 16,
   parameter int CNT_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [1:0]        wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              ord_en,
   input logic              gate_en,
   input logic              hit_a,
   input logic              hit_b,
   input logic              armed,
   input logic [CNT_W-1:0]  cnt_q,
   input logic              brk_o,
   input logic              flag_a_o
);
   // R3
   both_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ord_en && hit_a && hit_b |=> !brk_o);

   // R2
   unarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ord_en && !armed |=> !brk_o);

   // R8
   fire_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ord_en && armed && hit_b && !hit_a && (!gate_en || cnt_q == CNT_W'(1))
      |=> brk_o && !armed);

   // R7
   cnt_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q != '0);

   // R6
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ord_en && gate_en && armed && hit_b && !hit_a && cnt_q > CNT_W'(1)
      && !(wr_en && wr_addr == 2'd2) |=> cnt_q == $past(cnt_q) - CNT_W'(1));

   // R9
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag_a_o && !(wr_en && wr_addr == 2'd1 && !wr_data[0]) |=> flag_a_o);

   // R10
   direct_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ord_en && (hit_a || hit_b) |=> brk_o);
endmodule

bind seqbrk_top seqbrk_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .wr_data(wr_data), .ord_en(ord_en), .gate_en(gate_en),
   .hit_a(hit_a), .hit_b(hit_b), .armed(armed), .cnt_q(cnt_q),
   .brk_o(brk_o), .flag_a_o(flag_a_o)
);

// File: tb/seqbrk_top_tb_top.sv
module seqbrk_top_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int DATA_W = 16;
   localparam int NBUS   = 2;
   localparam int CNT_W  = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [1:0]        wr_addr = '0;
   logic [DATA_W-1:0] wr_data = '0;
   logic [NBUS-1:0]   a_hit = '0;
   logic [NBUS-1:0]   b_hit = '0;
   logic              brk_o, flag_a_o, flag_b_o;

   int vectors = 0;
   int errors  = 0;
   bit done    = 1'b0;
   int cur_src = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   seqbrk_top #(.DATA_W(DATA_W), .NBUS(NBUS), .CNT_W(CNT_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .a_hit(a_hit), .b_hit(b_hit),
      .brk_o(brk_o), .flag_a_o(flag_a_o), .flag_b_o(flag_b_o)
   );

   task automatic tick(input logic [NBUS-1:0] ah, input logic [NBUS-1:0] bh,
                       input logic we, input logic [1:0] ad,
                       input logic [DATA_W-1:0] d);
      @(negedge clk);
      a_hit = ah; b_hit = bh; wr_en = we; wr_addr = ad; wr_data = d;
      @(posedge clk);
      #1;
      a_hit = '0; b_hit = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
   endtask

   task automatic wr(input logic [1:0] ad, input int d);
      tick('0, '0, 1'b1, ad, DATA_W'(d));
   endtask

   task automatic ctrl(input bit ord, input bit gate, input int src);
      cur_src = src;
      wr(2'd0, int'(ord) | (int'(gate) << 1) | (src << 2));
   endtask

   task automatic hit(input bit a, input bit b);
      logic [NBUS-1:0] m;
      m = NBUS'(1) << cur_src;
      tick(a ? m : '0, b ? m : '0, 1'b0, 2'd0, '0);
   endtask

   task automatic chk(input string req, input logic act, input logic exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R11 reset state
      chk("R11 brk", brk_o, 1'b0);
      chk("R11 flag_a", flag_a_o, 1'b0);
      chk("R11 flag_b", flag_b_o, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      // R11: counter reset to 1 and mode clear; direct mode active after reset
      hit(1'b1, 1'b0);
      chk("R11 direct after reset", brk_o, 1'b1);
      wr(2'd1, 0);

      // R1 R6 R8 sweep over bus, gating and count load
      for (int src = 0; src < NBUS; src++) begin
         for (int ge = 0; ge < 2; ge++) begin
            for (int n = 1; n <= 4; n++) begin
               ctrl(1'b1, ge[0], src);
               wr(2'd2, n);
               wr(2'd1, 0);
               hit(1'b1, 1'b0);
               chk("R1 arm no brk", brk_o, 1'b0);
               chk("R9 flag_a set", flag_a_o, 1'b1);
               for (int k = 1; k <= n; k++) begin
                  hit(1'b0, 1'b1);
                  if (ge != 0) chk("R6 count gate", brk_o, k == n);
                  else         chk("R1 ordered fire", brk_o, k == 1);
               end
               hit(1'b0, 1'b0);
               chk("R1 pulse width", brk_o, 1'b0);
               hit(1'b0, 1'b1);
               chk("R8 disarmed", brk_o, 1'b0);
            end
         end
      end

      // R2 B before A
      ctrl(1'b1, 1'b0, 0);
      wr(2'd1, 0);
      hit(1'b0, 1'b1);
      chk("R2 B first", brk_o, 1'b0);
      chk("R9 flag_b set", flag_b_o, 1'b1);
      hit(1'b1, 1'b0);
      hit(1'b0, 1'b1);
      chk("R2 then A-B fires", brk_o, 1'b1);

      // R3 simultaneous
      hit(1'b1, 1'b1);
      chk("R3 unarmed both", brk_o, 1'b0);
      hit(1'b1, 1'b1);
      chk("R3 armed both", brk_o, 1'b0);
      hit(1'b0, 1'b1);
      chk("R3 A part armed", brk_o, 1'b1);

      // R4 cancel pending sequence
      hit(1'b1, 1'b0);
      ctrl(1'b0, 1'b0, 0);
      wr(2'd1, 0);
      chk("R4 flag_a cleared", flag_a_o, 1'b0);
      ctrl(1'b1, 1'b0, 0);
      hit(1'b0, 1'b1);
      chk("R4 cancelled", brk_o, 1'b0);

      // R5 other bus ignored
      ctrl(1'b1, 1'b0, 1);
      wr(2'd1, 0);
      tick(2'b01, 2'b00, 1'b0, 2'd0, '0);
      chk("R5 flag_a untouched", flag_a_o, 1'b0);
      tick(2'b00, 2'b01, 1'b0, 2'd0, '0);
      chk("R5 no brk", brk_o, 1'b0);
      chk("R5 flag_b untouched", flag_b_o, 1'b0);
      ctrl(1'b0, 1'b0, 1);
      tick(2'b01, 2'b01, 1'b0, 2'd0, '0);
      chk("R5 direct other bus", brk_o, 1'b0);

      // R7 zero load acts as one
      ctrl(1'b1, 1'b1, 0);
      wr(2'd2, 0);
      hit(1'b1, 1'b0);
      hit(1'b0, 1'b1);
      chk("R7 zero as one", brk_o, 1'b1);
      // R7 saturation: load 2, two A/B rounds; second round fires on first B
      wr(2'd2, 2);
      hit(1'b1, 1'b0);
      hit(1'b0, 1'b1);
      chk("R7 first of two", brk_o, 1'b0);
      hit(1'b0, 1'b1);
      chk("R7 second fires", brk_o, 1'b1);
      hit(1'b1, 1'b0);
      hit(1'b0, 1'b1);
      chk("R7 stays at one", brk_o, 1'b1);

      // R9 write 1 keeps, write 0 clears per bit
      hit(1'b1, 1'b1);
      wr(2'd1, 3);
      chk("R9 keep a", flag_a_o, 1'b1);
      chk("R9 keep b", flag_b_o, 1'b1);
      wr(2'd1, 2);
      chk("R9 clear a", flag_a_o, 1'b0);
      chk("R9 b kept", flag_b_o, 1'b1);
      wr(2'd1, 1);
      chk("R9 clear b", flag_b_o, 1'b0);

      // R10 direct mode
      ctrl(1'b0, 1'b0, 0);
      hit(1'b0, 1'b1);
      chk("R10 direct B", brk_o, 1'b1);
      hit(1'b1, 1'b0);
      chk("R10 direct A", brk_o, 1'b1);
      hit(1'b0, 1'b0);
      chk("R10 idle", brk_o, 1'b0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule